// File: doc/BRIEF.md
# Port Access Decoder with Mailboxes for a Bidirectional FIFO Pair

This block sits between two independently clocked ports and a pair of FIFOs carrying data in opposite directions: one FIFO from port A to port B, and one from port B to port A. On each port, a chip select, a direction input, an enable and a mailbox select are sampled on that port's own clock. The block turns them into one of four actions: a push into the outgoing FIFO, a pop from the incoming FIFO, a mailbox write, or a mailbox read. It also decides what drives each port's 36-bit bidirectional bus, and when that bus is released.

Each direction has one mailbox register with an active-low flag. The mailbox lets a single word bypass the FIFO queue. Writing the mailbox loads the word and pulls the flag low. A read with enable on the opposite port returns the flag high.

On port B, the mailbox is selected by a two-bit size input, and only when both bits are high. The FIFO arrays themselves are outside the block. The block sees them only through push/pop strobes, data and their full/empty flags.

Top module: `bififo_port_ctrl`

## Requirements
- R1: After reset, both mailbox flags read 1 (no mail) and a deselected port's bus is high-impedance.
- R2: With chip select high, the port's bus floats and no push, pop or mailbox action happens at its clock edge, whatever the other inputs are.
- R3: With chip select low and direction 1 (write), the bus floats. With enable 0 nothing happens. With enable 1, the word on the bus is pushed into the outgoing FIFO (mailbox select 0) or loaded into the outgoing mailbox (mailbox select 1) at the edge.
- R4: With chip select low and direction 0 (read), the port drives its bus whatever the enable is. Mailbox select 0 drives the incoming FIFO's output data and mailbox select 1 drives the incoming mailbox word. With enable 1, a pop strobe is issued (mailbox select 0).
- R5: A push is suppressed while the target FIFO's full flag is 0, and a pop is suppressed while the source FIFO's empty flag is 0.
- R6: On port B, the mailbox is selected only when size = 2'b11. Sizes 2'b00, 2'b01 and 2'b10 select the FIFO.
- R7: A mailbox write drives that mailbox's flag to 0 from the write edge on.
- R8: A mailbox read with enable 1 on the opposite port sets the flag back to 1 at that edge. Reading a mailbox whose flag is already 1 leaves it at 1.
- R9: A second write to a mailbox whose flag is 0 replaces the stored word, and the flag stays 0.
- R10: Port B mirrors port A: its writes go to the B-to-A FIFO or mailbox 2, and its reads take from the A-to-B FIFO or mailbox 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_en | input | 1 | Port A enable |
| a_mb | input | 1 | Port A mailbox select |
| a_bus | inout | 36 | Port A data bus |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_en | input | 1 | Port B enable |
| b_size | input | 2 | Port B size; 2'b11 selects the mailbox |
| b_bus | inout | 36 | Port B data bus |
| f1_push | output | 1 | Push strobe, A-to-B FIFO |
| f1_wdata | output | 36 | Push data, A-to-B FIFO |
| f1_full_n | input | 1 | A-to-B FIFO full flag, 0 = full |
| f1_pop | output | 1 | Pop strobe, A-to-B FIFO |
| f1_rdata | input | 36 | A-to-B FIFO output data |
| f1_empty_n | input | 1 | A-to-B FIFO empty flag, 0 = empty |
| f2_push | output | 1 | Push strobe, B-to-A FIFO |
| f2_wdata | output | 36 | Push data, B-to-A FIFO |
| f2_full_n | input | 1 | B-to-A FIFO full flag, 0 = full |
| f2_pop | output | 1 | Pop strobe, B-to-A FIFO |
| f2_rdata | input | 36 | B-to-A FIFO output data |
| f2_empty_n | input | 1 | B-to-A FIFO empty flag, 0 = empty |
| mb1_full_n | output | 1 | Mailbox 1 flag, 0 = mail present |
| mb2_full_n | output | 1 | Mailbox 2 flag, 0 = mail present |

## Verification
Strobes, push data and bus drive are combinational in the port inputs. They are due in the same cycle the inputs change, so the bench drives inputs just after a falling edge and checks these outputs 1 ns later, before any rising edge. Mailbox words and flags change only at the rising edge that samples an enabled mailbox action, so they are checked at the next falling edge. The bench also checks them with enable low, to show that nothing changes. Float is checked by comparing a released bus with all-Z, and non-driving during writes is checked by the bench's own value appearing on the bus without contention.

// File: rtl/bififo_port_ctrl.sv
module bififo_port_ctrl #(
  parameter int W = 36
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst_n,
  input  logic         a_cs_n,
  input  logic         a_wr,
  input  logic         a_en,
  input  logic         a_mb,
  inout  wire  [W-1:0] a_bus,
  input  logic         b_cs_n,
  input  logic         b_wr,
  input  logic         b_en,
  input  logic [1:0]   b_size,
  inout  wire  [W-1:0] b_bus,
  output logic         f1_push,
  output logic [W-1:0] f1_wdata,
  input  logic         f1_full_n,
  output logic         f1_pop,
  input  logic [W-1:0] f1_rdata,
  input  logic         f1_empty_n,
  output logic         f2_push,
  output logic [W-1:0] f2_wdata,
  input  logic         f2_full_n,
  output logic         f2_pop,
  input  logic [W-1:0] f2_rdata,
  input  logic         f2_empty_n,
  output logic         mb1_full_n,
  output logic         mb2_full_n
);

  logic a_oe, b_oe, a_wsel, a_rsel, b_wsel, b_rsel, b_mb;
  logic mb1_we, mb1_re, mb2_we, mb2_re;
  logic mb1_wt, mb1_rt, mb2_wt, mb2_rt;
  logic [W-1:0] mail1_q, mail2_q;

  assign a_oe   = !a_cs_n && !a_wr;
  assign b_oe   = !b_cs_n && !b_wr;
  assign a_wsel = !a_cs_n && a_en && a_wr;
  assign a_rsel = !a_cs_n && a_en && !a_wr;
  assign b_wsel = !b_cs_n && b_en && b_wr;
  assign b_rsel = !b_cs_n && b_en && !b_wr;
  assign b_mb   = &b_size;

  assign mb1_we  = a_wsel && a_mb;
  assign mb2_re  = a_rsel && a_mb;
  assign f1_push = a_wsel && !a_mb && f1_full_n;
  assign f2_pop  = a_rsel && !a_mb && f2_empty_n;

  assign mb2_we  = b_wsel && b_mb;
  assign mb1_re  = b_rsel && b_mb;
  assign f2_push = b_wsel && !b_mb && f2_full_n;
  assign f1_pop  = b_rsel && !b_mb && f1_empty_n;

  assign f1_wdata = a_bus;
  assign f2_wdata = b_bus;

  assign a_bus = a_oe ? (a_mb ? mail2_q : f2_rdata) : {W{1'bz}};
  assign b_bus = b_oe ? (b_mb ? mail1_q : f1_rdata) : {W{1'bz}};

  assign mb1_full_n = (mb1_wt == mb1_rt);
  assign mb2_full_n = (mb2_wt == mb2_rt);

  always_ff @(posedge clk_a or negedge rst_n)
    if (!rst_n) begin
      mail1_q <= '0;
      mb1_wt  <= 1'b0;
      mb2_rt  <= 1'b0;
    end else begin
      if (mb1_we) mail1_q <= a_bus;
      if (mb1_we && mb1_full_n) mb1_wt <= ~mb1_wt;
      if (mb2_re && !mb2_full_n) mb2_rt <= ~mb2_rt;
    end

  always_ff @(posedge clk_b or negedge rst_n)
    if (!rst_n) begin
      mail2_q <= '0;
      mb2_wt  <= 1'b0;
      mb1_rt  <= 1'b0;
    end else begin
      if (mb2_we) mail2_q <= b_bus;
      if (mb2_we && mb2_full_n) mb2_wt <= ~mb2_wt;
      if (mb1_re && !mb1_full_n) mb1_rt <= ~mb1_rt;
    end

  a_r2_idle_a: assert property (@(posedge clk_a) disable iff (!rst_n)
    a_cs_n |-> !f1_push && !f2_pop);
  a_r2_idle_b: assert property (@(posedge clk_b) disable iff (!rst_n)
    b_cs_n |-> !f2_push && !f1_pop);
  a_r5_no_push_full: assert property (@(posedge clk_a) disable iff (!rst_n)
    !f1_full_n |-> !f1_push);
  a_r5_no_pop_empty: assert property (@(posedge clk_b) disable iff (!rst_n)
    !f1_empty_n |-> !f1_pop);
  a_r6_size_fifo: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_size != 2'b11) |-> !mb2_we && !mb1_re);
  a_r7_flag_low: assert property (@(posedge clk_a) disable iff (!rst_n)
    (mb1_we && !mb1_re) |=> !mb1_full_n);
  a_r9_hold_word: assert property (@(posedge clk_a) disable iff (!rst_n)
    !mb1_we |=> $stable(mail1_q));

endmodule

// File: tb/test_bififo_port_ctrl.sv
module test_bififo_port_ctrl;
  localparam int W = 36;
  localparam logic [W-1:0] ZZ = {W{1'bz}};

  logic clk = 0;
  logic rst_n = 0;
  logic a_cs_n = 1, a_wr = 0, a_en = 0, a_mb = 0;
  logic b_cs_n = 1, b_wr = 0, b_en = 0;
  logic [1:0] b_size = 2'b00;
  logic [W-1:0] a_drv = '0, b_drv = '0;
  logic a_drv_en = 0, b_drv_en = 0;
  wire  [W-1:0] a_bus, b_bus;
  logic f1_full_n = 1, f1_empty_n = 1, f2_full_n = 1, f2_empty_n = 1;
  logic [W-1:0] f1_rdata = 36'h0AAAA5555, f2_rdata = 36'h123456789;
  logic f1_push, f1_pop, f2_push, f2_pop, mb1_full_n, mb2_full_n;
  logic [W-1:0] f1_wdata, f2_wdata;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  assign a_bus = a_drv_en ? a_drv : ZZ;
  assign b_bus = b_drv_en ? b_drv : ZZ;

  bififo_port_ctrl #(.W(W)) i_bififo_port_ctrl (
    .clk_a(clk), .clk_b(clk), .rst_n(rst_n),
    .a_cs_n(a_cs_n), .a_wr(a_wr), .a_en(a_en), .a_mb(a_mb), .a_bus(a_bus),
    .b_cs_n(b_cs_n), .b_wr(b_wr), .b_en(b_en), .b_size(b_size), .b_bus(b_bus),
    .f1_push(f1_push), .f1_wdata(f1_wdata), .f1_full_n(f1_full_n),
    .f1_pop(f1_pop), .f1_rdata(f1_rdata), .f1_empty_n(f1_empty_n),
    .f2_push(f2_push), .f2_wdata(f2_wdata), .f2_full_n(f2_full_n),
    .f2_pop(f2_pop), .f2_rdata(f2_rdata), .f2_empty_n(f2_empty_n),
    .mb1_full_n(mb1_full_n), .mb2_full_n(mb2_full_n));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    a_cs_n = 1; a_wr = 0; a_en = 0; a_mb = 0; a_drv_en = 0;
    b_cs_n = 1; b_wr = 0; b_en = 0; b_size = 2'b00; b_drv_en = 0;
    f1_full_n = 1; f1_empty_n = 1; f2_full_n = 1; f2_empty_n = 1;
  endtask

  task automatic t_reset();
    check("R1 mb1 flag", W'(mb1_full_n), W'(1));
    check("R1 mb2 flag", W'(mb2_full_n), W'(1));
    check("R1 a_bus float", a_bus, ZZ);
    check("R1 b_bus float", b_bus, ZZ);
  endtask

  task automatic t_deselect();
    a_cs_n = 1; a_wr = 0; a_en = 1; a_mb = 1; #1;
    check("R2 a_bus float on read", a_bus, ZZ);
    check("R2 no pop", W'(f2_pop), W'(0));
    a_wr = 1; a_mb = 0; #1;
    check("R2 no push", W'(f1_push), W'(0));
    a_mb = 1; a_drv_en = 1; a_drv = 36'h111111111;
    tick();
    check("R2 mailbox untouched", W'(mb1_full_n), W'(1));
    idle();
  endtask

  task automatic t_fifo_write();
    a_cs_n = 0; a_wr = 1; a_en = 0; a_mb = 0; a_drv_en = 1; a_drv = 36'h9ABCDEF01; #1;
    check("R3 no push with enable low", W'(f1_push), W'(0));
    check("R3 bus not driven by block", a_bus, 36'h9ABCDEF01);
    a_mb = 1; tick();
    check("R3 enable low leaves mailbox", W'(mb1_full_n), W'(1));
    a_mb = 0; a_en = 1; #1;
    check("R3 push strobe", W'(f1_push), W'(1));
    check("R3 push data", f1_wdata, 36'h9ABCDEF01);
    check("R3 no mailbox flag change", W'(mb1_full_n), W'(1));
    idle();
  endtask

  task automatic t_full_empty();
    a_cs_n = 0; a_wr = 1; a_en = 1; a_mb = 0; a_drv_en = 1; a_drv = 36'h1; f1_full_n = 0; #1;
    check("R5 push blocked when full", W'(f1_push), W'(0));
    idle();
    a_cs_n = 0; a_wr = 0; a_en = 1; a_mb = 0; f2_empty_n = 0; #1;
    check("R5 pop blocked when empty", W'(f2_pop), W'(0));
    f2_empty_n = 1; #1;
    check("R5 pop allowed when not empty", W'(f2_pop), W'(1));
    idle();
    b_cs_n = 0; b_wr = 0; b_en = 1; b_size = 2'b00; f1_empty_n = 0; #1;
    check("R5 port B pop blocked", W'(f1_pop), W'(0));
    idle();
    b_cs_n = 0; b_wr = 1; b_en = 1; b_size = 2'b01; b_drv_en = 1; b_drv = 36'h2; f2_full_n = 0; #1;
    check("R5 port B push blocked", W'(f2_push), W'(0));
    idle();
  endtask

  task automatic t_read_bus();
    a_cs_n = 0; a_wr = 0; a_en = 0; a_mb = 0; #1;
    check("R4 drives FIFO data with enable low", a_bus, f2_rdata);
    check("R4 no pop with enable low", W'(f2_pop), W'(0));
    a_mb = 1; #1;
    check("R4 drives mailbox word", a_bus, 36'h0);
    idle();
  endtask

  task automatic t_mail1();
    a_cs_n = 0; a_wr = 1; a_en = 1; a_mb = 1; a_drv_en = 1; a_drv = 36'hCAFEF00D5;
    tick();
    idle();
    check("R7 mb1 flag low after write", W'(mb1_full_n), W'(0));
    b_cs_n = 0; b_wr = 0; b_en = 0; b_size = 2'b11; #1;
    check("R10 port B drives mailbox 1", b_bus, 36'hCAFEF00D5);
    tick();
    check("R8 flag held without enable", W'(mb1_full_n), W'(0));
    b_en = 1; tick();
    check("R8 flag high after read", W'(mb1_full_n), W'(1));
    tick();
    check("R8 read of empty mailbox keeps flag", W'(mb1_full_n), W'(1));
    check("R8 word retained", b_bus, 36'hCAFEF00D5);
    idle();
  endtask

  task automatic t_overwrite();
    a_cs_n = 0; a_wr = 1; a_en = 1; a_mb = 1; a_drv_en = 1; a_drv = 36'h000000AA1;
    tick();
    a_drv = 36'h000000BB2;
    tick();
    idle();
    check("R9 flag stays low", W'(mb1_full_n), W'(0));
    b_cs_n = 0; b_wr = 0; b_size = 2'b11; #1;
    check("R9 newest word kept", b_bus, 36'h000000BB2);
    b_en = 1; tick();
    check("R9 flag high after read", W'(mb1_full_n), W'(1));
    idle();
  endtask

  task automatic t_size();
    for (int s = 0; s < 3; s++) begin
      b_cs_n = 0; b_wr = 0; b_en = 1; b_size = 2'(s); #1;
      check("R6 FIFO selected for size", b_bus, f1_rdata);
      check("R6 pop strobe", W'(f1_pop), W'(1));
      b_wr = 1; b_drv_en = 1; b_drv = 36'h777; #1;
      check("R6 push into B-to-A FIFO", W'(f2_push), W'(1));
      check("R10 push data", f2_wdata, 36'h777);
      tick();
      check("R6 mailbox 2 untouched", W'(mb2_full_n), W'(1));
      idle();
    end
    b_cs_n = 0; b_wr = 1; b_en = 1; b_size = 2'b11; b_drv_en = 1; b_drv = 36'h876543210; #1;
    check("R6 no push when mailbox selected", W'(f2_push), W'(0));
    tick();
    idle();
    check("R10 mb2 flag low", W'(mb2_full_n), W'(0));
    a_cs_n = 0; a_wr = 0; a_mb = 1; a_en = 0; #1;
    check("R10 port A reads mailbox 2", a_bus, 36'h876543210);
    a_en = 1; tick();
    check("R10 mb2 flag high after read", W'(mb2_full_n), W'(1));
    idle();
  endtask

  initial begin
    #1;
    t_reset();
    #20 rst_n = 1;
    @(negedge clk);
    t_deselect();
    t_fifo_write();
    t_full_empty();
    t_read_bus();
    t_mail1();
    t_overwrite();
    t_size();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule